// File: doc/BRIEF.md
# USB Device Link State Monitor

This block follows the state of a USB device's link to its host. It combines a power-present indication with decoded line symbols and a strobe for each valid start-of-frame (SOF) token. From these it keeps a three-bit link state, the current frame number and a flag for a host that has gone quiet. It also raises one-cycle event pulses that an interrupt or software layer can collect.

All time thresholds are counted in pulses of a free-running microsecond tick. The line-symbol decoder and the token parser sit upstream of this block. The effective power bit is either the sensed pin or a software override value. The raw pin stays visible on its own output.

The block also holds the device address that the host assigns. The address is cleared to zero whenever a link reset is detected.

Top module: `usb_link_monitor`

## Requirements
- R1: After reset the state output is 0, every event output is 0, the host-lost flag is 0, and the frame number and device address are 0. State codes: 0 unpowered, 1 powered (no reset seen yet), 2 suspended before any reset, 3 active with SOF, 4 suspended after activity, 5 active with no SOF since the last reset.
- R2: Line codes are 0 = SE0, 1 = J (idle), 2 = K, and 3 is treated like K. While powered, SE0 seen on RESET_TICKS+1 consecutive ticks (4 by default) moves the state to 5 and raises the link-reset pulse, once per SE0 period. An SE0 period that ends after fewer ticks has no effect.
- R3: J held for SUSPEND_TICKS+1 consecutive ticks (3001 by default) moves state 1 to 2, and moves state 3 or state 5 to 4. Either move raises the suspend pulse.
- R4: Any line code other than J while suspended raises the resume pulse. State 2 returns to 1. State 4 returns to whichever of 3 or 5 it was entered from.
- R5: A valid SOF loads the 11-bit frame number and raises the frame pulse one cycle later. In state 5 a valid SOF moves the state to 3.
- R6: In state 3 or 5, LOST_TICKS ticks (4096 by default) with no valid SOF set the host-lost flag and raise the host-lost pulse. The flag clears on a valid SOF, on a link reset and on loss of power.
- R7: Loss of effective power forces state 0 from any other state and raises the disconnect pulse. Power arriving in state 0 moves the state to 1 and raises the connect pulse. While unpowered, line activity has no effect.
- R8: When the override enable is 1, the override value replaces the sensed pin as the effective power. The raw sense output always follows the pin.
- R9: A device-address write loads the address register. A detected link reset clears the address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sense_raw_i | input | 1 | Power sense pin |
| pwr_ovr_en_i | input | 1 | Select override value as power |
| pwr_ovr_val_i | input | 1 | Override power value |
| line_i | input | 2 | Decoded line symbol (0 SE0, 1 J, 2 K) |
| tick_us_i | input | 1 | One pulse per microsecond |
| sof_valid_i | input | 1 | Valid SOF strobe |
| sof_frame_i | input | 11 | Frame number carried by the SOF |
| addr_we_i | input | 1 | Device address load strobe |
| addr_i | input | 7 | Device address to load |
| link_state_o | output | 3 | Encoded link state |
| frame_o | output | 11 | Last received frame number |
| host_lost_o | output | 1 | Host-lost flag |
| sense_raw_o | output | 1 | Raw power sense readback |
| dev_addr_o | output | 7 | Device address |
| ev_connect_o | output | 1 | Connect pulse |
| ev_disconnect_o | output | 1 | Disconnect pulse |
| ev_link_reset_o | output | 1 | Link-reset pulse |
| ev_suspend_o | output | 1 | Suspend pulse |
| ev_resume_o | output | 1 | Resume pulse |
| ev_host_lost_o | output | 1 | Host-lost pulse |
| ev_frame_o | output | 1 | Frame pulse |

## Verification
The bench checks the state one tick before and exactly at each threshold. A counter that is off by one would move the state a cycle early or late. It applies an SE0 period that is one tick too short, then breaks it with a K. A timer that failed to restart would then report a reset too soon. It enters suspend from both active states and from state 1, and checks that resume returns to the correct state. A design that forgot the prior state would come back to 3 instead of 5. It also clears the host-lost flag in each of its three ways, and applies SE0 while unpowered. A design that let SE0 through while unpowered would raise a reset without power.

// File: rtl/usb_link_pkg.sv
package usb_link_pkg;
  typedef enum logic [2:0] {
    LS_UNPOWERED = 3'd0,
    LS_POWERED   = 3'd1,
    LS_PWR_SUSP  = 3'd2,
    LS_ACTIVE    = 3'd3,
    LS_ACT_SUSP  = 3'd4,
    LS_NO_SOF    = 3'd5
  } link_state_e;

  localparam logic [1:0] LINE_SE0 = 2'd0;
  localparam logic [1:0] LINE_J   = 2'd1;
endpackage

// File: rtl/usb_link_hold_timer.sv
module usb_link_hold_timer #(
  parameter int LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cond_i,
  output logic det_o
);
  localparam int CW = $clog2(LIMIT + 2);

  logic [CW-1:0] cnt_q, cnt_d;

  assign det_o = cond_i && tick_i && (cnt_q == CW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (!cond_i) begin
      cnt_d = '0;
    end else if (tick_i && (cnt_q != CW'(LIMIT + 1))) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_DET_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |=> !det_o); // R2
endmodule

// File: rtl/usb_link_sof_watch.sv
module usb_link_sof_watch #(
  parameter int LOST_TICKS = 4096,
  parameter int FRAME_W    = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               active_i,
  input  logic               clr_i,
  input  logic               sof_valid_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               ev_frame_o,
  output logic               host_lost_o,
  output logic               ev_host_lost_o
);
  localparam int LCW = $clog2(LOST_TICKS + 1);

  logic [LCW-1:0]     cnt_q, cnt_d;
  logic [FRAME_W-1:0] frame_q;
  logic               lost_q, lost_d, ev_lost_q, ev_frame_q, det;

  assign det = active_i && tick_i && !sof_valid_i && !clr_i &&
               (cnt_q == LCW'(LOST_TICKS - 1));

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    if (sof_valid_i || clr_i || !active_i) begin
      cnt_d = '0;
    end else if (tick_i && (cnt_q != LCW'(LOST_TICKS))) begin
      cnt_d = cnt_q + LCW'(1);
    end
    if (sof_valid_i || clr_i) lost_d = 1'b0;
    else if (det)             lost_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      lost_q     <= 1'b0;
      ev_lost_q  <= 1'b0;
      ev_frame_q <= 1'b0;
      frame_q    <= '0;
    end else begin
      cnt_q      <= cnt_d;
      lost_q     <= lost_d;
      ev_lost_q  <= det;
      ev_frame_q <= sof_valid_i;
      if (sof_valid_i) frame_q <= sof_frame_i;
    end
  end

  assign frame_o        = frame_q;
  assign ev_frame_o     = ev_frame_q;
  assign host_lost_o    = lost_q;
  assign ev_host_lost_o = ev_lost_q;

  AST_SOF_CLEARS_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_valid_i |=> !lost_q); // R6
  AST_LOST_PULSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_lost_q |-> lost_q); // R6
endmodule

// File: rtl/usb_link_fsm.sv
module usb_link_fsm
  import usb_link_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwr_i,
  input  logic        reset_det_i,
  input  logic        idle_det_i,
  input  logic [1:0]  line_i,
  input  logic        sof_valid_i,
  output link_state_e state_o,
  output logic        reset_now_o,
  output logic        clr_lost_o,
  output logic        ev_connect_o,
  output logic        ev_disconnect_o,
  output logic        ev_reset_o,
  output logic        ev_suspend_o,
  output logic        ev_resume_o
);
  link_state_e state_q, state_d;
  logic from_act_q, from_act_d;
  logic conn_d, disc_d, rst_d, susp_d, res_d;
  logic conn_q, disc_q, rst_q, susp_q, res_q;

  always_comb begin
    state_d    = state_q;
    from_act_d = from_act_q;
    conn_d = 1'b0; disc_d = 1'b0; rst_d = 1'b0; susp_d = 1'b0; res_d = 1'b0;
    clr_lost_o = 1'b0;
    if (!pwr_i) begin
      if (state_q != LS_UNPOWERED) begin
        state_d    = LS_UNPOWERED;
        disc_d     = 1'b1;
        clr_lost_o = 1'b1;
      end
    end else if (state_q == LS_UNPOWERED) begin
      state_d = LS_POWERED;
      conn_d  = 1'b1;
    end else if (reset_det_i) begin
      state_d    = LS_NO_SOF;
      rst_d      = 1'b1;
      clr_lost_o = 1'b1;
    end else begin
      unique case (state_q)
        LS_POWERED: if (idle_det_i) begin
          state_d = LS_PWR_SUSP;
          susp_d  = 1'b1;
        end
        LS_ACTIVE, LS_NO_SOF: begin
          if (idle_det_i) begin
            state_d    = LS_ACT_SUSP;
            susp_d     = 1'b1;
            from_act_d = (state_q == LS_ACTIVE);
          end else if (sof_valid_i) begin
            state_d = LS_ACTIVE;
          end
        end
        LS_PWR_SUSP: if (line_i != LINE_J) begin
          state_d = LS_POWERED;
          res_d   = 1'b1;
        end
        LS_ACT_SUSP: if (line_i != LINE_J) begin
          state_d = from_act_q ? LS_ACTIVE : LS_NO_SOF;
          res_d   = 1'b1;
        end
        default: state_d = LS_UNPOWERED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= LS_UNPOWERED;
      from_act_q <= 1'b0;
      conn_q <= 1'b0; disc_q <= 1'b0; rst_q <= 1'b0; susp_q <= 1'b0; res_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      from_act_q <= from_act_d;
      conn_q <= conn_d; disc_q <= disc_d; rst_q <= rst_d; susp_q <= susp_d; res_q <= res_d;
    end
  end

  assign state_o         = state_q;
  assign reset_now_o     = rst_d;
  assign ev_connect_o    = conn_q;
  assign ev_disconnect_o = disc_q;
  assign ev_reset_o      = rst_q;
  assign ev_suspend_o    = susp_q;
  assign ev_resume_o     = res_q;

  AST_NO_POWER_UNPOWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_i |=> state_q == LS_UNPOWERED); // R7
  AST_RESET_ENTERS_NO_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i && state_q != LS_UNPOWERED && reset_det_i) |=> (state_q == LS_NO_SOF && rst_q)); // R2
  AST_POWERED_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i && state_q == LS_POWERED && !reset_det_i && idle_det_i) |=> state_q == LS_PWR_SUSP); // R3
  AST_RESUME_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_q |-> (state_q == LS_POWERED || state_q == LS_ACTIVE || state_q == LS_NO_SOF)); // R4
endmodule

// File: rtl/usb_link_monitor.sv
module usb_link_monitor
  import usb_link_pkg::*;
#(
  parameter int RESET_TICKS   = 3,
  parameter int SUSPEND_TICKS = 3000,
  parameter int LOST_TICKS    = 4096,
  parameter int FRAME_W       = 11,
  parameter int ADDR_W        = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sense_raw_i,
  input  logic               pwr_ovr_en_i,
  input  logic               pwr_ovr_val_i,
  input  logic [1:0]         line_i,
  input  logic               tick_us_i,
  input  logic               sof_valid_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  input  logic               addr_we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [2:0]         link_state_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               host_lost_o,
  output logic               sense_raw_o,
  output logic [ADDR_W-1:0]  dev_addr_o,
  output logic               ev_connect_o,
  output logic               ev_disconnect_o,
  output logic               ev_link_reset_o,
  output logic               ev_suspend_o,
  output logic               ev_resume_o,
  output logic               ev_host_lost_o,
  output logic               ev_frame_o
);
  logic        pwr, reset_det, idle_det, reset_now, clr_lost, active;
  link_state_e state;
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign pwr         = pwr_ovr_en_i ? pwr_ovr_val_i : sense_raw_i;
  assign sense_raw_o = sense_raw_i;

  usb_link_hold_timer #(.LIMIT(RESET_TICKS)) u_se0_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_us_i),
    .cond_i(line_i == LINE_SE0), .det_o(reset_det));

  usb_link_hold_timer #(.LIMIT(SUSPEND_TICKS)) u_idle_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_us_i),
    .cond_i(line_i == LINE_J), .det_o(idle_det));

  usb_link_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_i(pwr), .reset_det_i(reset_det),
    .idle_det_i(idle_det), .line_i(line_i), .sof_valid_i(sof_valid_i),
    .state_o(state), .reset_now_o(reset_now), .clr_lost_o(clr_lost),
    .ev_connect_o(ev_connect_o), .ev_disconnect_o(ev_disconnect_o),
    .ev_reset_o(ev_link_reset_o), .ev_suspend_o(ev_suspend_o),
    .ev_resume_o(ev_resume_o));

  assign active = (state == LS_ACTIVE) || (state == LS_NO_SOF);

  usb_link_sof_watch #(.LOST_TICKS(LOST_TICKS), .FRAME_W(FRAME_W)) u_sof_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_us_i), .active_i(active),
    .clr_i(clr_lost), .sof_valid_i(sof_valid_i), .sof_frame_i(sof_frame_i),
    .frame_o(frame_o), .ev_frame_o(ev_frame_o), .host_lost_o(host_lost_o),
    .ev_host_lost_o(ev_host_lost_o));

  always_comb begin
    addr_d = addr_q;
    if (reset_now)      addr_d = '0;
    else if (addr_we_i) addr_d = addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign dev_addr_o   = addr_q;
  assign link_state_o = state;

  AST_ADDR_CLEARED_ON_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_link_reset_o |-> dev_addr_o == '0); // R9
  AST_OVERRIDE_POWER_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ovr_en_i && !pwr_ovr_val_i) |=> link_state_o == 3'd0); // R8
endmodule

// File: tb/usb_link_monitor_test.sv
module usb_link_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sense = 1'b0, ovr_en = 1'b0, ovr_val = 1'b0;
  logic [1:0]  line = 2'd1;
  logic        tick = 1'b1, sof = 1'b0, addr_we = 1'b0;
  logic [10:0] sof_frame = '0;
  logic [6:0]  addr = '0;
  logic [2:0]  state;
  logic [10:0] frame;
  logic        lost, raw, e_con, e_dis, e_rst, e_sus, e_res, e_lost, e_frm;
  logic [6:0]  dev_addr;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  usb_link_monitor uut (
    .clk_i(clk), .rst_ni(rst_n), .sense_raw_i(sense), .pwr_ovr_en_i(ovr_en),
    .pwr_ovr_val_i(ovr_val), .line_i(line), .tick_us_i(tick), .sof_valid_i(sof),
    .sof_frame_i(sof_frame), .addr_we_i(addr_we), .addr_i(addr),
    .link_state_o(state), .frame_o(frame), .host_lost_o(lost), .sense_raw_o(raw),
    .dev_addr_o(dev_addr), .ev_connect_o(e_con), .ev_disconnect_o(e_dis),
    .ev_link_reset_o(e_rst), .ev_suspend_o(e_sus), .ev_resume_o(e_res),
    .ev_host_lost_o(e_lost), .ev_frame_o(e_frm));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sof_pulse(input logic [10:0] f);
    sof = 1'b1; sof_frame = f;
    adv(1);
    sof = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R1 state", state, 0);
    chk("R1 events", {e_con, e_dis, e_rst, e_sus, e_res, e_lost, e_frm}, 0);
    chk("R1 lost", lost, 0);
    chk("R1 frame", frame, 0);
    chk("R1 addr", dev_addr, 0);
  endtask

  task automatic t_power;
    sense = 1'b1; adv(1);
    chk("R7 connect state", state, 1);
    chk("R7 connect pulse", e_con, 1);
    adv(1);
    chk("R7 connect single", e_con, 0);
  endtask

  task automatic t_override;
    ovr_en = 1'b1; ovr_val = 1'b0; adv(1);
    chk("R8 override off state", state, 0);
    chk("R8 override disconnect", e_dis, 1);
    chk("R8 raw readback", raw, 1);
    ovr_val = 1'b1; adv(1);
    chk("R8 override on", state, 1);
    ovr_en = 1'b0; adv(1);
    chk("R8 pin power", state, 1);
  endtask

  task automatic t_link_reset;
    addr_we = 1'b1; addr = 7'h2A; adv(1); addr_we = 1'b0;
    chk("R9 addr load", dev_addr, 7'h2A);
    line = 2'd0; adv(3);
    chk("R2 short se0", state, 1);
    line = 2'd2; adv(1);
    line = 2'd0; adv(3);
    chk("R2 restarted se0", state, 1);
    adv(1);
    chk("R2 reset state", state, 5);
    chk("R2 reset pulse", e_rst, 1);
    chk("R9 addr cleared", dev_addr, 0);
    adv(1);
    chk("R2 reset single", e_rst, 0);
    line = 2'd2; adv(1);
  endtask

  task automatic t_sof;
    sof_pulse(11'h7FF);
    chk("R5 frame", frame, 11'h7FF);
    chk("R5 frame pulse", e_frm, 1);
    chk("R5 to active", state, 3);
    sof_pulse(11'h123);
    chk("R5 frame second", frame, 11'h123);
  endtask

  task automatic t_suspend_active;
    line = 2'd1; adv(3000);
    chk("R3 before suspend", state, 3);
    adv(1);
    chk("R3 active suspend", state, 4);
    chk("R3 suspend pulse", e_sus, 1);
    line = 2'd2; adv(1);
    chk("R4 resume to active", state, 3);
    chk("R4 resume pulse", e_res, 1);
  endtask

  task automatic t_host_lost;
    sof_pulse(11'h005);
    adv(4095);
    chk("R6 not yet lost", lost, 0);
    adv(1);
    chk("R6 lost flag", lost, 1);
    chk("R6 lost pulse", e_lost, 1);
    sof_pulse(11'h006);
    chk("R6 sof clears", lost, 0);
    adv(4096);
    chk("R6 lost again", lost, 1);
    line = 2'd0; adv(4);
    chk("R6 reset clears", lost, 0);
    chk("R2 reset from active", state, 5);
    line = 2'd2; adv(1);
  endtask

  task automatic t_resume_nosof;
    line = 2'd1; adv(3001);
    chk("R3 nosof suspend", state, 4);
    line = 2'd2; adv(1);
    chk("R4 resume to nosof", state, 5);
    adv(4100);
    chk("R6 lost in nosof", lost, 1);
    sense = 1'b0; adv(1);
    chk("R7 disconnect state", state, 0);
    chk("R7 disconnect pulse", e_dis, 1);
    chk("R6 power loss clears", lost, 0);
  endtask

  task automatic t_powered_suspend;
    line = 2'd0; adv(6);
    chk("R7 se0 ignored unpowered", state, 0);
    chk("R7 no reset pulse", e_rst, 0);
    line = 2'd2; sense = 1'b1; adv(1);
    chk("R7 reconnect", state, 1);
    line = 2'd1; adv(3000);
    chk("R3 powered before", state, 1);
    adv(1);
    chk("R3 powered suspend", state, 2);
    chk("R3 powered pulse", e_sus, 1);
    line = 2'd2; adv(1);
    chk("R4 resume to powered", state, 1);
    chk("R4 powered pulse", e_res, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    adv(1);
    t_reset_state;
    t_power;
    t_override;
    t_link_reset;
    t_sof;
    t_suspend_active;
    t_host_lost;
    t_resume_nosof;
    t_powered_suspend;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule